// File: doc/BRIEF.md
# Processor Operating-Mode Sequencer

This block keeps track of which operating mode a small processor core is in. It moves the core through power-up reset, vector fetch, normal execution, interrupt and trap entry, bus hand-over to an external master, and three power-down modes. The rest of the core tells it when each step finishes. In return it drives one strobe per sequence step, a bus grant, and two clock enables, one for the core and one for the peripherals.

All decisions are taken on the rising clock edge. The current mode is registered, and every output is decoded from that registered mode. A new input therefore shows up on the outputs one cycle later. `arst_n` is the chip's power-on reset for the flops. `rst_n` and `stby_n` are the processor's own reset and hardware-standby pins, and they are sampled synchronously.

Internal states, each with its one-hot mode bit in brackets:
- RESET [0]
- RSTEXC, the vector fetch [1]
- RUN [2]
- EXC_PC, EXC_CCR and EXC_IBIT, which together form exception entry [3]
- BUSREL [4]
- SLEEP [5]
- SWSTBY [6]
- HWSTBY [7]

Transitions:
- Any state goes to HWSTBY while `stby_n` is low.
- Any state goes to RESET while `rst_n` is low.
- HWSTBY goes to RESET, and RESET goes to RSTEXC.
- RSTEXC goes to RUN.
- RUN goes to BUSREL, EXC_PC, SLEEP or SWSTBY.
- EXC_PC goes to EXC_CCR, or to BUSREL.
- EXC_CCR goes to EXC_IBIT or RUN, or to BUSREL.
- EXC_IBIT goes to RUN.
- BUSREL goes back to its saved return state.
- SLEEP and SWSTBY go to EXC_PC.

Top module: `opstate_ctrl`

## Requirements
- R1: While `stby_n` is high and `rst_n` is low at a clock edge, the next state is RESET (mode bit 0), whatever the current state.
- R2: A low `stby_n` at a clock edge forces HWSTBY (mode bit 7), even if `rst_n` is low. From HWSTBY a high `stby_n` leads to RESET.
- R3: From RESET, a high `rst_n` leads to RSTEXC, where `vec_fetch` is 1. RSTEXC moves to RUN on `step_done`.
- R4: Interrupts (`nmi`, `ext_irq`, `per_irq`) are ignored in RSTEXC and at the first `step_done` boundary in RUN after it. After that boundary they are accepted again.
- R5: In RUN, `sleep_exec` together with `step_done` enters SWSTBY (mode bit 6) when `ssby`=1, and SLEEP (mode bit 5) when `ssby`=0.
- R6: SWSTBY is left only by `nmi` or any `ext_irq` bit. SLEEP is also left by any `per_irq` bit. Both lead to EXC_PC.
- R7: Exception entry keeps `push_pc` high until `step_done`, then keeps `push_ccr` high until `step_done`. After that, `ue`=1 gives one cycle of `ibit_set` before RUN, and `ue`=0 returns straight to RUN.
- R8: `bus_req` at a `step_done` boundary in RUN, EXC_PC or EXC_CCR enters BUSREL with `bus_grant`=1. When `bus_req` drops, the state goes to RUN, EXC_CCR, or the step that follows EXC_CCR, respectively.
- R9: At a RUN boundary the priority is: bus request first, then an exception (accepted interrupt or `trap_exec`), then `sleep_exec`.
- R10: `trap_exec` at a RUN boundary starts exception entry even inside the post-reset mask window.
- R11: `core_clk_en` is 0 in SLEEP, SWSTBY and HWSTBY. `per_clk_en` is 0 only in SWSTBY and HWSTBY.
- R12: `state_oh` always has exactly one bit set, and after `arst_n` it reads RESET (8'h01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-on reset of the flops, active low |
| rst_n | input | 1 | Processor reset pin, active low, sampled |
| stby_n | input | 1 | Hardware standby pin, active low, sampled |
| step_done | input | 1 | Current instruction or sequence step has finished |
| sleep_exec | input | 1 | The finishing instruction is SLEEP |
| trap_exec | input | 1 | The finishing instruction is a trap |
| ssby | input | 1 | Power-down select: 1 gives software standby, 0 gives sleep |
| ue | input | 1 | Set the interrupt mask bit at exception entry |
| bus_req | input | 1 | External bus master request |
| nmi | input | 1 | Non-maskable interrupt request |
| ext_irq | input | NUM_EXT_IRQ | External interrupt requests that can wake from standby |
| per_irq | input | NUM_PER_IRQ | Peripheral interrupt requests |
| state_oh | output | 8 | One-hot mode (bit order as in the state list) |
| vec_fetch | output | 1 | Start-vector fetch request |
| push_pc | output | 1 | Push the program counter onto the stack |
| push_ccr | output | 1 | Push the condition code register |
| ibit_set | output | 1 | One-cycle strobe that sets the interrupt mask bit |
| bus_grant | output | 1 | Bus released to the external master |
| core_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |

## Verification
The hardest case to reach from the ports is a bus release in the middle of exception entry. The request has to coincide with a push step boundary, and the saved return state only becomes visible after the grant drops. The bench reaches it by first starting an exception with `nmi` and then raising `bus_req` together with `step_done` in EXC_PC. The post-reset mask window is similar, because it only matters at the very first boundary after a vector fetch. Directed sequences therefore re-enter reset before testing both the interrupt and the trap at that boundary. A long biased-random phase follows, and a behavioural model compares every output every cycle.

// File: rtl/opstate_pkg.sv
package opstate_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_RSTEXC,
        ST_RUN,
        ST_EXC_PC,
        ST_EXC_CCR,
        ST_EXC_IBIT,
        ST_BUSREL,
        ST_SLEEP,
        ST_SWSTBY,
        ST_HWSTBY
    } opst_e;

    localparam int NUM_MODES   = 8;
    localparam int MODE_RESET  = 0;
    localparam int MODE_RSTEXC = 1;
    localparam int MODE_RUN    = 2;
    localparam int MODE_EXC    = 3;
    localparam int MODE_BUSREL = 4;
    localparam int MODE_SLEEP  = 5;
    localparam int MODE_SWSTBY = 6;
    localparam int MODE_HWSTBY = 7;

    // Architectural mode index of an internal state
    function automatic int mode_of(opst_e s);
        unique case (s)
            ST_RESET:                            return MODE_RESET;
            ST_RSTEXC:                           return MODE_RSTEXC;
            ST_RUN:                              return MODE_RUN;
            ST_EXC_PC, ST_EXC_CCR, ST_EXC_IBIT:  return MODE_EXC;
            ST_BUSREL:                           return MODE_BUSREL;
            ST_SLEEP:                            return MODE_SLEEP;
            ST_SWSTBY:                           return MODE_SWSTBY;
            default:                             return MODE_HWSTBY;
        endcase
    endfunction

endpackage

// File: rtl/opstate_intc.sv
module opstate_intc
    import opstate_pkg::*;
#(
    parameter int NUM_EXT_IRQ = 3,
    parameter int NUM_PER_IRQ = 4
) (
    input  logic                   clk,
    input  logic                   arst_n,
    input  opst_e                  state,
    input  logic                   step_done,
    input  logic                   nmi,
    input  logic [NUM_EXT_IRQ-1:0] ext_irq,
    input  logic [NUM_PER_IRQ-1:0] per_irq,
    output logic                   run_int,
    output logic                   slp_wake,
    output logic                   sby_wake
);

    logic mask_q;
    logic stby_src;
    logic any_src;

    assign stby_src = nmi | (|ext_irq);
    assign any_src  = stby_src | (|per_irq);

    // Mask window: armed through reset and vector fetch, dropped at the
    // first completed step in RUN.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            mask_q <= 1'b1;
        end else if (state == ST_RESET || state == ST_RSTEXC || state == ST_HWSTBY) begin
            mask_q <= 1'b1;
        end else if (state == ST_RUN && step_done) begin
            mask_q <= 1'b0;
        end
    end

    assign run_int  = any_src & ~mask_q;
    assign slp_wake = any_src;
    assign sby_wake = stby_src;

    // R4
    mask_after_vec_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_RSTEXC) |=> mask_q);

endmodule

// File: rtl/opstate_fsm.sv
module opstate_fsm
    import opstate_pkg::*;
(
    input  logic  clk,
    input  logic  arst_n,
    input  logic  rst_n,
    input  logic  stby_n,
    input  logic  step_done,
    input  logic  sleep_exec,
    input  logic  trap_exec,
    input  logic  ssby,
    input  logic  ue,
    input  logic  bus_req,
    input  logic  run_int,
    input  logic  slp_wake,
    input  logic  sby_wake,
    output opst_e state_q
);

    opst_e nxt;
    opst_e ret_q;
    opst_e ret_d;
    opst_e follow;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_RESET;
            ret_q   <= ST_RUN;
        end else begin
            state_q <= nxt;
            ret_q   <= ret_d;
        end
    end

    always_comb begin
        nxt    = state_q;
        ret_d  = ret_q;
        follow = ST_RUN;
        if (!stby_n) begin
            nxt = ST_HWSTBY;
        end else if (!rst_n) begin
            nxt = ST_RESET;
        end else begin
            unique case (state_q)
                ST_HWSTBY: nxt = ST_RESET;
                ST_RESET:  nxt = ST_RSTEXC;
                ST_RSTEXC: if (step_done) nxt = ST_RUN;
                ST_RUN: begin
                    if (step_done) begin
                        if (bus_req) begin
                            ret_d = ST_RUN;
                            nxt   = ST_BUSREL;
                        end else if (run_int || trap_exec) begin
                            nxt = ST_EXC_PC;
                        end else if (sleep_exec) begin
                            nxt = ssby ? ST_SWSTBY : ST_SLEEP;
                        end
                    end
                end
                ST_EXC_PC, ST_EXC_CCR: begin
                    if (state_q == ST_EXC_PC) follow = ST_EXC_CCR;
                    else                      follow = ue ? ST_EXC_IBIT : ST_RUN;
                    if (step_done) begin
                        if (bus_req) begin
                            ret_d = follow;
                            nxt   = ST_BUSREL;
                        end else begin
                            nxt = follow;
                        end
                    end
                end
                ST_EXC_IBIT: nxt = ST_RUN;
                ST_BUSREL:   if (!bus_req) nxt = ret_q;
                ST_SLEEP:    if (slp_wake) nxt = ST_EXC_PC;
                ST_SWSTBY:   if (sby_wake) nxt = ST_EXC_PC;
                default:     nxt = ST_RESET;
            endcase
        end
    end

    // R2
    hwstby_force_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !stby_n |=> state_q == ST_HWSTBY);
    // R1
    reset_force_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (stby_n && !rst_n) |=> state_q == ST_RESET);
    // R3
    vec_done_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (stby_n && rst_n && state_q == ST_RSTEXC && step_done) |=> state_q == ST_RUN);
    // R4
    first_boundary_masked_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (stby_n && rst_n && state_q == ST_RUN && $past(state_q) == ST_RSTEXC && step_done
         && !bus_req && !trap_exec && !sleep_exec) |=> state_q == ST_RUN);
    // R6
    swstby_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (stby_n && rst_n && state_q == ST_SWSTBY && !sby_wake) |=> state_q == ST_SWSTBY);
    // R7
    no_ibit_without_ue_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (stby_n && rst_n && state_q == ST_EXC_CCR && step_done && !bus_req && !ue)
        |=> state_q == ST_RUN);
    // R8
    bus_return_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (stby_n && rst_n && state_q == ST_BUSREL && !bus_req) |=> state_q == $past(ret_q));

endmodule

// File: rtl/opstate_outdec.sv
module opstate_outdec
    import opstate_pkg::*;
(
    input  opst_e                state,
    output logic [NUM_MODES-1:0] state_oh,
    output logic                 vec_fetch,
    output logic                 push_pc,
    output logic                 push_ccr,
    output logic                 ibit_set,
    output logic                 bus_grant,
    output logic                 core_clk_en,
    output logic                 per_clk_en
);

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        assign state_oh[m] = (mode_of(state) == m);
    end

    always_comb begin
        vec_fetch   = 1'b0;
        push_pc     = 1'b0;
        push_ccr    = 1'b0;
        ibit_set    = 1'b0;
        bus_grant   = 1'b0;
        core_clk_en = 1'b1;
        per_clk_en  = 1'b1;
        unique case (state)
            ST_RSTEXC:   vec_fetch = 1'b1;
            ST_EXC_PC:   push_pc   = 1'b1;
            ST_EXC_CCR:  push_ccr  = 1'b1;
            ST_EXC_IBIT: ibit_set  = 1'b1;
            ST_BUSREL:   bus_grant = 1'b1;
            ST_SLEEP:    core_clk_en = 1'b0;
            ST_SWSTBY, ST_HWSTBY: begin
                core_clk_en = 1'b0;
                per_clk_en  = 1'b0;
            end
            default: ;
        endcase
    end

    always_comb begin
        // R11
        per_gates_core_chk: assert (per_clk_en || !core_clk_en);
        // R12
        onehot_mode_chk: assert ($countones(state_oh) == 1);
    end

endmodule

// File: rtl/opstate_ctrl.sv
module opstate_ctrl
    import opstate_pkg::*;
#(
    parameter int NUM_EXT_IRQ = 3,
    parameter int NUM_PER_IRQ = 4
) (
    input  logic                   clk,
    input  logic                   arst_n,
    input  logic                   rst_n,
    input  logic                   stby_n,
    input  logic                   step_done,
    input  logic                   sleep_exec,
    input  logic                   trap_exec,
    input  logic                   ssby,
    input  logic                   ue,
    input  logic                   bus_req,
    input  logic                   nmi,
    input  logic [NUM_EXT_IRQ-1:0] ext_irq,
    input  logic [NUM_PER_IRQ-1:0] per_irq,
    output logic [7:0]             state_oh,
    output logic                   vec_fetch,
    output logic                   push_pc,
    output logic                   push_ccr,
    output logic                   ibit_set,
    output logic                   bus_grant,
    output logic                   core_clk_en,
    output logic                   per_clk_en
);

    opst_e state;
    logic  run_int;
    logic  slp_wake;
    logic  sby_wake;

    opstate_intc #(
        .NUM_EXT_IRQ(NUM_EXT_IRQ),
        .NUM_PER_IRQ(NUM_PER_IRQ)
    ) u_intc (
        .clk      (clk),
        .arst_n   (arst_n),
        .state    (state),
        .step_done(step_done),
        .nmi      (nmi),
        .ext_irq  (ext_irq),
        .per_irq  (per_irq),
        .run_int  (run_int),
        .slp_wake (slp_wake),
        .sby_wake (sby_wake)
    );

    opstate_fsm u_fsm (
        .clk       (clk),
        .arst_n    (arst_n),
        .rst_n     (rst_n),
        .stby_n    (stby_n),
        .step_done (step_done),
        .sleep_exec(sleep_exec),
        .trap_exec (trap_exec),
        .ssby      (ssby),
        .ue        (ue),
        .bus_req   (bus_req),
        .run_int   (run_int),
        .slp_wake  (slp_wake),
        .sby_wake  (sby_wake),
        .state_q   (state)
    );

    opstate_outdec u_out (
        .state      (state),
        .state_oh   (state_oh),
        .vec_fetch  (vec_fetch),
        .push_pc    (push_pc),
        .push_ccr   (push_ccr),
        .ibit_set   (ibit_set),
        .bus_grant  (bus_grant),
        .core_clk_en(core_clk_en),
        .per_clk_en (per_clk_en)
    );

endmodule

// File: tb/opstate_ctrl_bench.sv
module opstate_ctrl_bench;

    localparam int NE = 3;
    localparam int NP = 4;

    // model state codes
    localparam int M_RESET = 0, M_VEC = 1, M_RUN = 2, M_PC = 3, M_CCR = 4, M_IB = 5,
                   M_BUS = 6, M_SLP = 7, M_SSB = 8, M_HWS = 9;

    logic clk = 1'b0;
    logic arst_n, rst_n, stby_n, step_done, sleep_exec, trap_exec, ssby, ue, bus_req, nmi;
    logic [NE-1:0] ext_irq;
    logic [NP-1:0] per_irq;
    logic [7:0] state_oh;
    logic vec_fetch, push_pc, push_ccr, ibit_set, bus_grant, core_clk_en, per_clk_en;

    int checks = 0;
    int errors = 0;
    int m_st   = M_RESET;
    int m_ret  = M_RUN;
    bit m_mask = 1'b1;
    string req = "R12";

    opstate_ctrl #(.NUM_EXT_IRQ(NE), .NUM_PER_IRQ(NP)) u_opstate_ctrl (
        .clk(clk), .arst_n(arst_n), .rst_n(rst_n), .stby_n(stby_n),
        .step_done(step_done), .sleep_exec(sleep_exec), .trap_exec(trap_exec),
        .ssby(ssby), .ue(ue), .bus_req(bus_req), .nmi(nmi),
        .ext_irq(ext_irq), .per_irq(per_irq), .state_oh(state_oh),
        .vec_fetch(vec_fetch), .push_pc(push_pc), .push_ccr(push_ccr),
        .ibit_set(ibit_set), .bus_grant(bus_grant),
        .core_clk_en(core_clk_en), .per_clk_en(per_clk_en)
    );

    always #4 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic int mode_bit(int s);
        case (s)
            M_RESET: return 0;
            M_VEC:   return 1;
            M_RUN:   return 2;
            M_PC, M_CCR, M_IB: return 3;
            M_BUS:   return 4;
            M_SLP:   return 5;
            M_SSB:   return 6;
            default: return 7;
        endcase
    endfunction

    task automatic compare();
        logic [14:0] act, exp;
        act = {state_oh, vec_fetch, push_pc, push_ccr, ibit_set, bus_grant, core_clk_en, per_clk_en};
        exp = {8'(1 << mode_bit(m_st)), m_st == M_VEC, m_st == M_PC, m_st == M_CCR, m_st == M_IB,
               m_st == M_BUS, !(m_st == M_SLP || m_st == M_SSB || m_st == M_HWS),
               !(m_st == M_SSB || m_st == M_HWS)};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t act=%h exp=%h", req, $time, act, exp);
        end
    endtask

    task automatic tick();
        int  n;
        bit  any_i, sb_i;
        n     = m_st;
        sb_i  = nmi || (|ext_irq);
        any_i = sb_i || (|per_irq);
        if (!stby_n) n = M_HWS;
        else if (!rst_n) n = M_RESET;
        else begin
            case (m_st)
                M_HWS:   n = M_RESET;
                M_RESET: n = M_VEC;
                M_VEC:   if (step_done) n = M_RUN;
                M_RUN: if (step_done) begin
                    if (bus_req) begin m_ret = M_RUN; n = M_BUS; end
                    else if ((any_i && !m_mask) || trap_exec) n = M_PC;
                    else if (sleep_exec) n = ssby ? M_SSB : M_SLP;
                end
                M_PC:  if (step_done) begin
                    if (bus_req) begin m_ret = M_CCR; n = M_BUS; end else n = M_CCR;
                end
                M_CCR: if (step_done) begin
                    if (bus_req) begin m_ret = ue ? M_IB : M_RUN; n = M_BUS; end
                    else n = ue ? M_IB : M_RUN;
                end
                M_IB:  n = M_RUN;
                M_BUS: if (!bus_req) n = m_ret;
                M_SLP: if (any_i) n = M_PC;
                M_SSB: if (sb_i) n = M_PC;
                default: n = M_RESET;
            endcase
        end
        if (m_st == M_RESET || m_st == M_VEC || m_st == M_HWS) m_mask = 1'b1;
        else if (m_st == M_RUN && step_done) m_mask = 1'b0;
        @(posedge clk);
        m_st = n;
        #2;
        compare();
    endtask

    task automatic quiet();
        step_done = 0; sleep_exec = 0; trap_exec = 0; bus_req = 0; nmi = 0;
        ext_irq = '0; per_irq = '0;
    endtask

    task automatic steps(int k);
        step_done = 1;
        for (int i = 0; i < k; i++) tick();
        step_done = 0;
    endtask

    initial begin
        arst_n = 0; rst_n = 0; stby_n = 1; ssby = 0; ue = 1;
        quiet();
        repeat (3) @(posedge clk);
        #2 arst_n = 1;
        #1 req = "R12"; compare();

        req = "R1";  repeat (3) tick();
        rst_n = 1; req = "R3"; tick(); tick(); steps(1);
        // R4: interrupt at first boundary is ignored
        req = "R4"; nmi = 1; steps(1);
        steps(1);
        nmi = 0;
        req = "R7"; ue = 1; steps(2); tick(); tick();
        // R10 path plus ue=0
        req = "R7"; ue = 0; trap_exec = 1; steps(1); trap_exec = 0; steps(2); tick();
        // R5 / R6 sleep
        req = "R5"; sleep_exec = 1; ssby = 0; steps(1); sleep_exec = 0; tick(); tick();
        req = "R6"; per_irq = 4'b0100; tick(); per_irq = '0; steps(2);
        req = "R5"; sleep_exec = 1; ssby = 1; steps(1); sleep_exec = 0;
        req = "R11"; tick(); tick();
        req = "R6"; per_irq = 4'b1001; repeat (3) tick(); per_irq = '0;
        ext_irq = 3'b100; tick(); ext_irq = '0; steps(2); tick();
        // R8 bus release from RUN and from EXC_PC
        req = "R8"; bus_req = 1; steps(1); tick(); tick(); bus_req = 0; tick();
        nmi = 1; steps(1); nmi = 0; bus_req = 1; steps(1); tick(); bus_req = 0; tick();
        steps(1); tick();
        // R9 priority
        req = "R9"; bus_req = 1; nmi = 1; trap_exec = 1; sleep_exec = 1; steps(1);
        bus_req = 0; tick(); steps(1); quiet(); steps(2); tick();
        // R10 trap inside the mask window
        req = "R10"; rst_n = 0; tick(); rst_n = 1; tick(); steps(1);
        trap_exec = 1; steps(1); trap_exec = 0; steps(2); tick();
        // R2 hardware standby
        req = "R2"; stby_n = 0; tick(); rst_n = 0; tick(); tick();
        stby_n = 1; tick(); rst_n = 1; tick(); steps(2);
        sleep_exec = 1; ssby = 0; steps(1); sleep_exec = 0; stby_n = 0; tick(); stby_n = 1; tick();
        // mixed random traffic, every requirement in play
        req = "R12";
        for (int i = 0; i < 4000; i++) begin
            stby_n     = ($urandom_range(0, 99) != 0);
            rst_n      = ($urandom_range(0, 59) != 0);
            step_done  = $urandom_range(0, 1);
            sleep_exec = ($urandom_range(0, 7) == 0);
            trap_exec  = ($urandom_range(0, 15) == 0);
            ssby       = $urandom_range(0, 1);
            ue         = $urandom_range(0, 1);
            if ($urandom_range(0, 5) == 0) bus_req = ~bus_req;
            nmi        = ($urandom_range(0, 31) == 0);
            ext_irq    = ($urandom_range(0, 9) == 0) ? NE'($urandom) : '0;
            per_irq    = ($urandom_range(0, 7) == 0) ? NP'($urandom) : '0;
            tick();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule